// File: doc/BRIEF.md
# EEPROM Addressing-Scheme Detector

This controller sits above a byte-access sequencer that talks to a serial EEPROM. It finds out whether the attached memory takes one address byte or two. A single `start` pulse launches a fixed two-step probe through the sequencer's request interface. The first step is a write of the probe byte 0x01 to address 0 using the two-address-byte format. The second step is a read of address 0 using the one-address-byte format.

The two kinds of memory store different values at location 0. A memory that takes two address bytes stores 0x01 there. A memory that takes one address byte treats the second address byte as data. It stores 0x00 at location 0 and 0x01 at location 1. The short-format read therefore returns 0x01 for a two-byte-address device and 0x00 for a one-byte-address device. Any other value, or an error reported by the sequencer, ends the probe with an error flag instead of a verdict.

The probe overwrites locations 0 and 1 of the memory. Each step waits for the sequencer's done pulse before the next request is issued.

Top module: `eeprom_scheme_detect`

## Requirements
- R1: After reset, `seq_req`, `busy`, `det_valid`, `det_wide` and `det_err` are all 0.
- R2: A `start` seen while idle raises `busy`. In the next cycle it produces a one-cycle request with `seq_write`=1, `seq_wide`=1, `seq_addr`=0 and `seq_wdata`=0x01.
- R3: Every request lasts exactly one cycle. No further request is made until the sequencer returns `seq_done` for the current one.
- R4: A write that completes with `seq_err`=0 is followed, in the next cycle, by a one-cycle read request with `seq_write`=0, `seq_wide`=0 and `seq_addr`=0.
- R5: If the read returns 0x01 with no error, the cycle after `seq_done` shows `det_valid`=1, `det_wide`=1 and `det_err`=0.
- R6: If the read returns 0x00 with no error, the cycle after `seq_done` shows `det_valid`=1, `det_wide`=0 and `det_err`=0.
- R7: If the read returns any value other than 0x00 or 0x01, the cycle after `seq_done` shows `det_valid`=1, `det_err`=1 and `det_wide`=0.
- R8: If the write completes with `seq_err`=1, no read request is made. The cycle after `seq_done` shows `det_valid`=1 and `det_err`=1.
- R9: If the read completes with `seq_err`=1, the cycle after `seq_done` shows `det_valid`=1 and `det_err`=1, whatever the returned byte.
- R10: A `start` while busy has no effect. A `seq_done` while idle produces no request and no `det_valid`.
- R11: `det_valid` lasts one cycle and `busy` is 0 in that cycle. `det_wide` and `det_err` hold their values until the next accepted `start`, which clears both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one detection run |
| busy | output | 1 | A run is in progress |
| seq_req | output | 1 | One-cycle request to the sequencer |
| seq_write | output | 1 | Request is a write (1) or a read (0) |
| seq_wide | output | 1 | Request uses two address bytes (1) or one (0) |
| seq_addr | output | ADDR_W | Memory address of the request |
| seq_wdata | output | DATA_W | Byte to write |
| seq_rdata | input | DATA_W | Byte returned by a read, valid with `seq_done` |
| seq_done | input | 1 | Sequencer finished the current request |
| seq_err | input | 1 | Sequencer reports failure, valid with `seq_done` |
| det_valid | output | 1 | One-cycle result strobe |
| det_wide | output | 1 | Memory takes two address bytes |
| det_err | output | 1 | Detection failed |

## Verification
The probe is run with several read-back bytes:
- 0x01 tells a two-byte-address memory apart.
- 0x00 tells a one-byte-address memory apart.
- 0x5A and 0xFF show that an unexpected byte gives an error rather than a verdict.

Sequencer errors are injected separately on the write step and on the read step. These runs show that a failed write suppresses the read, and that a failed read overrides whatever byte came back. Different done latencies show that the controller waits for the done pulse and never issues a second request early. Stray `start` and `seq_done` pulses show that both are ignored in the wrong state.

// File: rtl/esd_pkg.sv
package esd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_ISSUE,
    ST_WR_WAIT,
    ST_RD_ISSUE,
    ST_RD_WAIT
  } esd_state_e;

  typedef enum logic [1:0] {
    VD_NARROW,
    VD_WIDE,
    VD_BAD
  } esd_verdict_e;

endpackage

// File: rtl/esd_step_fsm.sv
module esd_step_fsm
  import esd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PROBE  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              seq_done,
  input  logic              seq_err,
  output logic              busy,
  output logic              seq_req,
  output logic              seq_write,
  output logic              seq_wide,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [DATA_W-1:0] seq_wdata,
  output logic              ev_accept,
  output logic              ev_fail,
  output logic              ev_read_ok
);

  localparam logic [ADDR_W-1:0] PROBE_ADDR = '0;
  localparam logic [DATA_W-1:0] PROBE_BYTE = DATA_W'(PROBE);

  esd_state_e state_q, state_d;

  logic wr_done, rd_done;

  assign ev_accept  = start && (state_q == ST_IDLE);
  assign wr_done    = seq_done && (state_q == ST_WR_WAIT);
  assign rd_done    = seq_done && (state_q == ST_RD_WAIT);
  assign ev_fail    = (wr_done || rd_done) && seq_err;
  assign ev_read_ok = rd_done && !seq_err;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start)    state_d = ST_WR_ISSUE;
      ST_WR_ISSUE:               state_d = ST_WR_WAIT;
      ST_WR_WAIT:  if (seq_done) state_d = seq_err ? ST_IDLE : ST_RD_ISSUE;
      ST_RD_ISSUE:               state_d = ST_RD_WAIT;
      ST_RD_WAIT:  if (seq_done) state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy      = (state_q != ST_IDLE);
  assign seq_req   = (state_q == ST_WR_ISSUE) || (state_q == ST_RD_ISSUE);
  assign seq_write = (state_q == ST_WR_ISSUE);
  assign seq_wide  = (state_q == ST_WR_ISSUE);
  assign seq_addr  = PROBE_ADDR;
  assign seq_wdata = PROBE_BYTE;

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req |=> !seq_req); // R3
  AST_ACCEPT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (seq_req && seq_write && seq_wide)); // R2
  AST_READ_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_req && !seq_write) |-> !seq_wide); // R4
  AST_WR_FAIL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && seq_err) |=> !seq_req); // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !seq_done) |=> !seq_req); // R10

endmodule

// File: rtl/esd_verdict.sv
module esd_verdict
  import esd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PROBE  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              fail,
  input  logic              read_ok,
  input  logic [DATA_W-1:0] rdata,
  output logic              det_valid,
  output logic              det_wide,
  output logic              det_err
);

  localparam logic [DATA_W-1:0] WIDE_BYTE   = DATA_W'(PROBE);
  localparam logic [DATA_W-1:0] NARROW_BYTE = '0;

  function automatic esd_verdict_e classify(input logic [DATA_W-1:0] b);
    if (b == WIDE_BYTE)        return VD_WIDE;
    else if (b == NARROW_BYTE) return VD_NARROW;
    else                       return VD_BAD;
  endfunction

  esd_verdict_e verdict;
  assign verdict = classify(rdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      det_valid <= 1'b0;
      det_wide  <= 1'b0;
      det_err   <= 1'b0;
    end else begin
      det_valid <= fail || read_ok;
      if (clear) begin
        det_wide <= 1'b0;
        det_err  <= 1'b0;
      end else if (fail) begin
        det_wide <= 1'b0;
        det_err  <= 1'b1;
      end else if (read_ok) begin
        det_wide <= (verdict == VD_WIDE);
        det_err  <= (verdict == VD_BAD);
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid |=> !det_valid); // R11
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid |-> !(det_wide && det_err)); // R7
  AST_FAIL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> (det_valid && det_err)); // R9

endmodule

// File: rtl/eeprom_scheme_detect.sv
module eeprom_scheme_detect #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PROBE  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              seq_req,
  output logic              seq_write,
  output logic              seq_wide,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [DATA_W-1:0] seq_wdata,
  input  logic [DATA_W-1:0] seq_rdata,
  input  logic              seq_done,
  input  logic              seq_err,
  output logic              det_valid,
  output logic              det_wide,
  output logic              det_err
);

  logic ev_accept, ev_fail, ev_read_ok;

  esd_step_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROBE(PROBE)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .seq_done   (seq_done),
    .seq_err    (seq_err),
    .busy       (busy),
    .seq_req    (seq_req),
    .seq_write  (seq_write),
    .seq_wide   (seq_wide),
    .seq_addr   (seq_addr),
    .seq_wdata  (seq_wdata),
    .ev_accept  (ev_accept),
    .ev_fail    (ev_fail),
    .ev_read_ok (ev_read_ok)
  );

  esd_verdict #(.DATA_W(DATA_W), .PROBE(PROBE)) u_verdict (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (ev_accept),
    .fail      (ev_fail),
    .read_ok   (ev_read_ok),
    .rdata     (seq_rdata),
    .det_valid (det_valid),
    .det_wide  (det_wide),
    .det_err   (det_err)
  );

  AST_VALID_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid |-> !busy); // R11

endmodule

// File: tb/sim_eeprom_scheme_detect.sv
module sim_eeprom_scheme_detect;

  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic seq_done = 1'b0;
  logic seq_err = 1'b0;
  logic [DW-1:0] seq_rdata = '0;
  logic busy, seq_req, seq_write, seq_wide, det_valid, det_wide, det_err;
  logic [AW-1:0] seq_addr;
  logic [DW-1:0] seq_wdata;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  eeprom_scheme_detect #(.ADDR_W(AW), .DATA_W(DW), .PROBE(1)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .seq_req(seq_req), .seq_write(seq_write), .seq_wide(seq_wide),
    .seq_addr(seq_addr), .seq_wdata(seq_wdata), .seq_rdata(seq_rdata),
    .seq_done(seq_done), .seq_err(seq_err),
    .det_valid(det_valid), .det_wide(det_wide), .det_err(det_err)
  );

  // vector: read byte, write error, read error, done latency
  localparam int NV = 6;
  localparam logic [13:0] VEC [NV] = '{
    {8'h01, 1'b0, 1'b0, 4'd1},
    {8'h00, 1'b0, 1'b0, 4'd3},
    {8'h5A, 1'b0, 1'b0, 4'd2},
    {8'hFF, 1'b0, 1'b0, 4'd1},
    {8'h01, 1'b1, 1'b0, 4'd2},
    {8'h00, 1'b0, 1'b1, 4'd4}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive after sampling at the falling edge
  task automatic run_one(input logic [7:0] rv, input bit we, input bit re, input int lat);
    bit exp_err, exp_wide;
    exp_err  = we || re || (rv != 8'h01 && rv != 8'h00);
    exp_wide = !exp_err && (rv == 8'h01);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(seq_req && seq_write && seq_wide && busy, "R2 write request", {seq_req, seq_write, seq_wide, busy}, 4'hF);
    chk(seq_addr == 0 && seq_wdata == 8'h01, "R2 write addr/data", {seq_addr, seq_wdata}, 24'h000001);
    chk(!det_wide && !det_err, "R11 flags cleared by start", {det_wide, det_err}, 0);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(!seq_req, "R3 no request while waiting", seq_req, 0);
    end
    seq_done = 1'b1; seq_err = we;
    @(negedge clk); seq_done = 1'b0; seq_err = 1'b0;
    if (we) begin
      chk(det_valid && det_err && !seq_req, "R8 write error ends run", {det_valid, det_err, seq_req}, 3'b110);
    end else begin
      chk(seq_req && !seq_write && !seq_wide && seq_addr == 0, "R4 read request",
          {seq_req, seq_write, seq_wide}, 3'b100);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk(!seq_req, "R3 no request while waiting", seq_req, 0);
      end
      seq_done = 1'b1; seq_err = re; seq_rdata = rv;
      @(negedge clk); seq_done = 1'b0; seq_err = 1'b0; seq_rdata = 8'h00;
      chk(det_valid && !busy, "R11 strobe with busy low", {det_valid, busy}, 2'b10);
      if (re) chk(det_err == 1'b1, "R9 read error", det_err, 1);
      else if (exp_wide) chk(det_wide && !det_err, "R5 wide verdict", {det_wide, det_err}, 2'b10);
      else if (!exp_err) chk(!det_wide && !det_err, "R6 narrow verdict", {det_wide, det_err}, 2'b00);
      else chk(det_err && !det_wide, "R7 bad byte", {det_wide, det_err}, 2'b01);
    end
    @(negedge clk);
    chk(!det_valid && det_wide == exp_wide && det_err == exp_err, "R11 pulse ends, flags hold",
        {det_valid, det_wide, det_err}, {1'b0, exp_wide, exp_err});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!seq_req && !busy && !det_valid && !det_wide && !det_err, "R1 reset state",
        {seq_req, busy, det_valid, det_wide, det_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NV; v++)
      run_one(VEC[v][13:6], VEC[v][5], VEC[v][4], int'(VEC[v][3:0]));

    // R10: done pulse while idle
    seq_done = 1'b1; seq_rdata = 8'h01;
    @(negedge clk); seq_done = 1'b0; seq_rdata = 8'h00;
    chk(!seq_req && !det_valid && !busy, "R10 stray done ignored", {seq_req, det_valid, busy}, 0);
    @(negedge clk);
    chk(!seq_req && !det_valid, "R10 stray done ignored later", {seq_req, det_valid}, 0);

    // R10: start while busy
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(seq_req && seq_write, "R2 accepted start", {seq_req, seq_write}, 2'b11);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!seq_req && busy, "R10 start while busy ignored", {seq_req, busy}, 2'b01);
    seq_done = 1'b1;
    @(negedge clk); seq_done = 1'b0;
    chk(seq_req && !seq_write, "R4 read after repeated start", {seq_req, seq_write}, 2'b10);
    @(negedge clk);
    seq_done = 1'b1; seq_rdata = 8'h00;
    @(negedge clk); seq_done = 1'b0;
    chk(det_valid && !det_wide && !det_err, "R6 narrow after repeated start", {det_valid, det_wide, det_err}, 3'b100);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!seq_req && !busy, "R10 no extra run", {seq_req, busy}, 0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule